// File: doc/BRIEF.md
# Two-Channel External Interrupt Sense Controller

This block is the front end for two external interrupt pins on a small microcontroller. Each pin first passes through a two-flop synchronizer and then a sampling register. All detection works on the sampled value. A 2-bit sense field for each channel picks the event that raises an interrupt: a low level, any change, a falling edge or a rising edge.

In the three edge modes, a detected event sets a sticky flag. The flag is set whether or not the channel is masked. It clears when the CPU acknowledges the channel, or when software writes a 1 to that flag bit. In low-level mode nothing is latched: the request simply follows the sampled level.

A channel only drives its request when its mask bit and the global interrupt enable are both set. A combined request output reports the winning channel, and channel 0 takes priority over channel 1. Software reaches the sense-control, mask and flag registers through a simple address/write-strobe port with combinational read data.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every register reads zero: sense control (address 0), mask (address 1) and flag (address 2). No request is asserted while the pins idle high.
- R2: In the sense-control register, channel n owns bits [2n+1:2n]. Code 00 selects low level, 01 any change, 10 falling edge and 11 rising edge. Bits 7:4 ignore writes and read zero.
- R3: A pin change applied before a rising clock edge appears in the flag register after the fourth rising edge. It is not yet visible after the third.
- R4: In any-change mode, both a rising and a falling transition of the sampled pin set the channel flag.
- R5: Falling-edge mode flags only high-to-low transitions. Rising-edge mode flags only low-to-high transitions.
- R6: In edge modes, a detected event sets the flag even when the channel's mask bit or the global enable is clear.
- R7: In edge modes, a channel's request is high exactly when its flag, its mask bit and the global enable are all set.
- R8: In low-level mode, the request follows the live sampled pin: high while the pin is low, and dropping once the pin returns high with nothing remembered. The channel's flag bit reads zero in this mode.
- R9: A one-cycle acknowledge pulse clears a pending flag. Writing 1 to a flag bit at address 2 clears that flag, and writing 0 leaves it unchanged. An event in the same cycle as a clear wins, so the flag stays set.
- R10: The combined request output is high when any channel requests. The reported channel index is the lowest-numbered requesting channel, so channel 0 beats channel 1.
- R11: Mask bits above the channel count ignore writes and read zero. Address 3 reads zero.
- R12: A pin pulse lasting one full clock period, applied between falling clock edges, is detected in rising-edge mode and in any-change mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Raw external interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_CH | Per-channel acknowledge pulse from the CPU |
| reg_addr_i | input | ADDR_W | Register address (0 sense, 1 mask, 2 flag) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Combinational register read data |
| irq_req_o | output | NUM_CH | Per-channel gated interrupt request |
| irq_any_o | output | 1 | Any channel requesting |
| irq_id_o | output | ID_W | Index of the highest-priority requesting channel |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit data path, a 2-bit address and two synchronizer stages. With two channels, the priority encoder has a real contest to resolve. The reserved upper halves of the sense and mask registers also exist, so their write-masking can be observed.

The two stages fix the pin-to-flag latency at four edges, and the bench checks that latency edge by edge. This depth also lets the bench place an acknowledge in the exact cycle an event arrives, and time single-period pulses against the sampling chain.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int REG_SENSE = 0;
    localparam int REG_MASK  = 1;
    localparam int REG_FLAG  = 2;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] samp_o,
    output logic [NUM_CH-1:0] prev_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_CH-1:0] sync;
        logic [NUM_CH-1:0]                  samp;
        logic [NUM_CH-1:0]                  prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.samp = st_q.sync[SYNC_STAGES-1];
        st_d.prev = st_q.samp;
    end

    // Idle-high reset avoids a false falling edge on pins that rest high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign samp_o = st_q.samp;
    assign prev_o = st_q.prev;

    // R3: the compare stage always holds the previous sample
    a_r3_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(samp_o));

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    input  logic [NUM_CH-1:0]   flag_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic [2*NUM_CH-1:0] sense_o,
    output logic [NUM_CH-1:0]   mask_o,
    output logic [NUM_CH-1:0]   w1c_o
);

    localparam logic [DATA_W-1:0] SENSE_KEEP = DATA_W'((1 << (2*NUM_CH)) - 1);
    localparam logic [DATA_W-1:0] MASK_KEEP  = DATA_W'((1 << NUM_CH) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sense;
        logic [DATA_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic hit_sense, hit_mask, hit_flag;

    always_comb begin
        hit_sense = (reg_addr_i == ADDR_W'(REG_SENSE));
        hit_mask  = (reg_addr_i == ADDR_W'(REG_MASK));
        hit_flag  = (reg_addr_i == ADDR_W'(REG_FLAG));

        st_d = st_q;
        if (reg_wr_i && hit_sense) st_d.sense = reg_wdata_i & SENSE_KEEP;
        if (reg_wr_i && hit_mask)  st_d.mask  = reg_wdata_i & MASK_KEEP;

        w1c_o = (reg_wr_i && hit_flag) ? reg_wdata_i[NUM_CH-1:0] : '0;

        if (hit_sense)     reg_rdata_o = st_q.sense;
        else if (hit_mask) reg_rdata_o = st_q.mask;
        else if (hit_flag) reg_rdata_o = DATA_W'(flag_i);
        else               reg_rdata_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sense_o = st_q.sense[2*NUM_CH-1:0];
    assign mask_o  = st_q.mask[NUM_CH-1:0];

    // R2: sense field only moves on a write to its address
    a_r2_sense_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && hit_sense) |=> $stable(sense_o));
    // R11: mask only moves on a write to its address
    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && hit_mask) |=> $stable(mask_o));

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sense_i,
    input  logic       samp_i,
    input  logic       prev_i,
    input  logic       mask_i,
    input  logic       gie_i,
    input  logic       ack_i,
    input  logic       w1c_i,
    output logic       flag_o,
    output logic       req_o
);

    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;
    sense_e mode;
    logic   rise, fall, evt, clr, raw_req;

    always_comb begin
        mode = sense_e'(sense_i);
        rise = samp_i & ~prev_i;
        fall = ~samp_i & prev_i;
        case (mode)
            SENSE_ANY:  evt = rise | fall;
            SENSE_FALL: evt = fall;
            SENSE_RISE: evt = rise;
            default:    evt = 1'b0;
        endcase
        clr = ack_i | w1c_i;

        st_d = st_q;
        if (mode == SENSE_LOW) st_d.flag = 1'b0;
        else if (evt)          st_d.flag = 1'b1;
        else if (clr)          st_d.flag = 1'b0;

        raw_req = (mode == SENSE_LOW) ? ~samp_i : st_q.flag;
        req_o   = raw_req & mask_i & gie_i;
        flag_o  = st_q.flag & (mode != SENSE_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: no request without mask and global enable
    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (mask_i && gie_i));
    // R6: an edge event always leaves the flag set
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LOW && evt && $stable(sense_i)) |=> st_q.flag);
    // R9: a clear with no competing event drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && (ack_i || w1c_i)) |=> !st_q.flag);
    // R8: a high sampled pin in level mode never requests
    a_r8_level_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW && samp_i) |-> !req_o);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ID_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              gie_i,
    input  logic [NUM_CH-1:0] ack_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [NUM_CH-1:0] irq_req_o,
    output logic              irq_any_o,
    output logic [ID_W-1:0]   irq_id_o
);

    logic [NUM_CH-1:0]   samp, prev, mask, w1c, flag, req;
    logic [2*NUM_CH-1:0] sense;

    ext_irq_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .samp_o(samp), .prev_o(prev)
    );

    ext_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .flag_i(flag), .reg_rdata_o(reg_rdata_o),
        .sense_o(sense), .mask_o(mask), .w1c_o(w1c)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ext_irq_chan chan_i (
            .clk(clk), .rst_n(rst_n),
            .sense_i(sense[2*c +: 2]),
            .samp_i(samp[c]), .prev_i(prev[c]),
            .mask_i(mask[c]), .gie_i(gie_i),
            .ack_i(ack_i[c]), .w1c_i(w1c[c]),
            .flag_o(flag[c]), .req_o(req[c])
        );
    end

    always_comb begin
        irq_id_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) irq_id_o = ID_W'(i);
        end
        irq_any_o = |req;
        irq_req_o = req;
    end

    // R10: the reported index always names a requesting channel
    a_r10_id_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o |-> irq_req_o[irq_id_o]);
    // R10: channel 0 wins whenever it requests
    a_r10_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o[0] |-> irq_id_o == '0);

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam logic [1:0] A_SENSE = 2'd0, A_MASK = 2'd1, A_FLAG = 2'd2, A_NONE = 2'd3;

    typedef struct packed {
        logic [1:0] mode;
        logic       from_l;
        logic       to_l;
        logic       e0;
        logic       e1;
    } vec_t;

    // ch0 makes from->to; ch1 makes the inverse transition
    localparam vec_t VEC [8] = '{
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'b10, 1'b1, 1'b0, 1'b1, 1'b0},
        '{2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'b11, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] pin = '1;
    logic              gie = 1'b0;
    logic [NUM_CH-1:0] ack = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NUM_CH-1:0] irq_req;
    logic              irq_any;
    logic [0:0]        irq_id;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sense dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie), .ack_i(ack),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_req_o(irq_req), .irq_any_o(irq_any),
        .irq_id_o(irq_id)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(6);

        // R1: reset state
        reg_read(A_SENSE, rd); check("R1 sense", rd, 8'h00);
        reg_read(A_MASK, rd);  check("R1 mask", rd, 8'h00);
        reg_read(A_FLAG, rd);  check("R1 flag", rd, 8'h00);
        check("R1 req", {6'd0, irq_req}, 8'h00);

        // R4 R5 R8: mode table
        for (int v = 0; v < 8; v++) begin
            reg_write(A_SENSE, {4'h0, VEC[v].mode, VEC[v].mode});
            pin = {~VEC[v].from_l, VEC[v].from_l};
            idle(6);
            reg_write(A_FLAG, 8'h03);
            idle(1);
            pin = {~VEC[v].to_l, VEC[v].to_l};
            idle(6);
            reg_read(A_FLAG, rd);
            check($sformatf("R4/R5/R8 vec%0d", v), rd, {6'd0, VEC[v].e1, VEC[v].e0});
        end

        // R2: reserved sense bits
        reg_write(A_SENSE, 8'hFF);
        reg_read(A_SENSE, rd); check("R2 reserved", rd, 8'h0F);
        // R11: mask upper bits and empty address
        reg_write(A_MASK, 8'hFF);
        reg_read(A_MASK, rd); check("R11 mask", rd, 8'h03);
        reg_read(A_NONE, rd); check("R11 addr3", rd, 8'h00);
        reg_write(A_MASK, 8'h00);

        // R3: latency, ch0 rising, ch1 level
        reg_write(A_SENSE, 8'h03);
        pin = 2'b10;
        idle(6);
        reg_write(A_FLAG, 8'h03);
        pin[0] = 1'b1;
        reg_addr = A_FLAG;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R3 edge3", {7'd0, reg_rdata[0]}, 8'h00);
        @(posedge clk);
        @(negedge clk); #1;
        check("R3 edge4", {7'd0, reg_rdata[0]}, 8'h01);

        // R6: flag set while masked, no request
        check("R6 masked req", {6'd0, irq_req}, 8'h00);
        reg_write(A_MASK, 8'h01);
        #1; check("R7 gie off", {6'd0, irq_req}, 8'h00);
        gie = 1'b1;
        #1; check("R7 req", {5'd0, irq_id, irq_req}, 8'h01);
        check("R7 any", {7'd0, irq_any}, 8'h01);

        // R9: write-one-to-clear
        reg_write(A_FLAG, 8'h00);
        reg_read(A_FLAG, rd); check("R9 w0 keeps", rd, 8'h01);
        reg_write(A_FLAG, 8'h01);
        reg_read(A_FLAG, rd); check("R9 w1 clears", rd, 8'h00);
        check("R9 req off", {6'd0, irq_req}, 8'h00);

        // R9: event beats acknowledge in the same cycle (ch0 falling)
        reg_write(A_SENSE, 8'h02);
        idle(2);
        pin[0] = 1'b0;
        reg_addr = A_FLAG;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ack[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack[0] = 1'b0;
        #1; check("R9 set wins", {7'd0, reg_rdata[0]}, 8'h01);
        ack[0] = 1'b1;
        @(negedge clk);
        ack[0] = 1'b0;
        #1; check("R9 ack clears", {7'd0, reg_rdata[0]}, 8'h00);

        // R8: level mode on ch1, no latching
        reg_write(A_MASK, 8'h03);
        pin[1] = 1'b0;
        idle(4);
        check("R8 level req", {6'd0, irq_req}, 8'h02);
        reg_read(A_FLAG, rd); check("R8 flag zero", rd, 8'h00);
        pin[1] = 1'b1;
        idle(4);
        check("R8 released", {6'd0, irq_req}, 8'h00);

        // R10: priority
        pin[0] = 1'b1;
        idle(5);
        pin = 2'b00;
        idle(5);
        check("R10 both", {5'd0, irq_id, irq_req}, 8'h03);
        ack[0] = 1'b1;
        @(negedge clk);
        ack[0] = 1'b0;
        #1; check("R10 ch1 wins", {5'd0, irq_id, irq_req}, 8'h06);
        pin[1] = 1'b1;
        idle(4);
        check("R10 idle", {7'd0, irq_any}, 8'h00);

        // R12: one-period pulse, rising then any-change
        reg_write(A_MASK, 8'h01);
        reg_write(A_SENSE, 8'h03);
        reg_write(A_FLAG, 8'h03);
        pin[0] = 1'b1;
        @(negedge clk);
        pin[0] = 1'b0;
        idle(6);
        reg_read(A_FLAG, rd); check("R12 rise pulse", rd, 8'h01);
        reg_write(A_SENSE, 8'h01);
        reg_write(A_FLAG, 8'h03);
        reg_read(A_FLAG, rd); check("R12 cleared", rd, 8'h00);
        pin[0] = 1'b1;
        @(negedge clk);
        pin[0] = 1'b0;
        idle(6);
        reg_read(A_FLAG, rd); check("R12 any pulse", rd, 8'h01);

        finish_run();
    end

endmodule